// File: doc/BRIEF.md
# PAL Line and Field Timing Counters

This block keeps the raster position for a PAL-rate CCD camera timing generator. A master clock is divided into a t1 tick of four clocks. A horizontal counter advances on every tick and covers one 64 µs line in 214 ticks. A vertical counter runs at half-line resolution: it steps twice per line, so one field is 625 counts and one frame is 1250 counts. A frame-parity bit and the field half together give a two-bit field number that runs through a four-field sequence.

Two external synchronization inputs can realign the raster. Each input passes through a two-flop synchronizer and a small arming state machine. The machine has three states: `EDGE_HELD` (input high, disarmed), `EDGE_ARMED` (input seen low, waiting for a rise) and `EDGE_PEND` (rise seen, waiting for the next tick). Its transitions are:
- HELD→ARMED when the synchronized input is low.
- ARMED→PEND when the synchronized input is high.
- PEND→HELD on a tick while the input is still high.
- PEND→ARMED on a tick after the input has fallen.

The tick taken while in PEND presets its counter, the horizontal one to 6 and the vertical one to 16. Both synchronizers reset to high, so an input that is already high out of reset does not count as a rising edge.

The field number and a decoded line gate pass through output registers that load on the tick. They therefore describe the count that held before that tick, one tick late.

Top module: `pal_video_timer`

## Requirements
- R1: A tick occurs on every TICK_DIV-th clock edge after reset release (edges TICK_DIV, 2·TICK_DIV, …). No output changes on any other edge.
- R2: On a tick without a horizontal preset, `h_count` goes up by one, wrapping from H_TOTAL−1 to 0.
- R3: `v_count` steps up by one on a tick that moves `h_count` naturally to 0 or to H_TOTAL/2. It wraps from V_TOTAL−1 to 0 and does not change on other ticks.
- R4: Encoding of `field_id`:
  - bit 0 is 1 when the count is at or above V_TOTAL/2 (second half of the frame);
  - bit 1 is a frame parity that toggles whenever `v_count` wraps to 0;
  - in free run the values 0,1,2,3 therefore all appear.
- R5: `field_id` and `line_gate` load on a tick from the counts held just before that tick, so they lag the counters by one tick.
- R6: `line_gate` is 1 exactly when the previous-tick `h_count` lies in [GATE_START, GATE_END).
- R7: Horizontal preset timing:
  - if `hsync_rst_in` is first sampled high at clock edge E after having been low, `h_count` becomes H_PRESET at the first tick edge at or after E+3;
  - on that tick it does not increment.
- R8: A vertical rise with the same timing sets `v_count` to V_PRESET. The frame parity is left unchanged.
- R9: A rise presets its counter only once. A further preset needs the input to go low first. An input that is high through reset causes no preset.
- R10: Priority when a preset shares a tick with a natural step:
  - a horizontal preset on the tick that would wrap or half-step the line suppresses the vertical step;
  - a vertical preset overrides a vertical step on the same tick.
- R11: During reset, `h_count`, `v_count`, `field_id` and `line_gate` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_rst_in | input | 1 | External horizontal preset request, asynchronous, rising edge |
| vsync_rst_in | input | 1 | External vertical preset request, asynchronous, rising edge |
| h_count | output | $clog2(H_TOTAL) | Horizontal position in ticks |
| v_count | output | $clog2(V_TOTAL) | Vertical position in half lines |
| field_id | output | 2 | Field number of the previous tick |
| line_gate | output | 1 | Decoded horizontal window of the previous tick |

## Verification
An external preset can fall on the same tick as the counters' own line wrap or half-line step. The bench provokes this by waiting until, right after a tick, the next tick is the natural wrap (or half step). It then raises the reset input(s) on the following falling clock edge, so the synchronized edge is applied on exactly that tick. It judges the result at the ports:
- a horizontal preset alone leaves `v_count` unchanged;
- a vertical preset gives V_PRESET rather than the stepped value;
- both presets together give the two preset values.

// File: rtl/pvt_pkg.sv
package pvt_pkg;
    typedef enum logic [1:0] {
        EDGE_HELD  = 2'd0,
        EDGE_ARMED = 2'd1,
        EDGE_PEND  = 2'd2
    } edge_state_e;
endpackage

// File: rtl/pvt_tick_gen.sv
module pvt_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] DLAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          div_q <= '0;
        else if (div_q == DLAST) div_q <= '0;
        else                 div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == DLAST);

    generate
        if (TICK_DIV > 1) begin : g_gap
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R1
        end
    endgenerate
endmodule

// File: rtl/pvt_edge_arm.sv
module pvt_edge_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic take_o
);
    import pvt_pkg::*;

    logic [1:0]  sync_q;
    logic        level;
    edge_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pin_i};
    end
    assign level = sync_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDGE_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_HELD:  if (!level) state_d = EDGE_ARMED;
            EDGE_ARMED: if (level)  state_d = EDGE_PEND;
            EDGE_PEND:  if (tick_i) state_d = level ? EDGE_HELD : EDGE_ARMED;
            default:    state_d = EDGE_HELD;
        endcase
    end

    always_comb begin
        take_o = (state_q == EDGE_PEND) && tick_i;
    end

    AST_TAKE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o); // R9
    AST_PEND_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDGE_HELD) |=> (state_q != EDGE_PEND)); // R9
endmodule

// File: rtl/pvt_line_frame_ctr.sv
module pvt_line_frame_ctr #(
    parameter int H_TOTAL  = 214,
    parameter int V_TOTAL  = 1250,
    parameter int H_PRESET = 6,
    parameter int V_PRESET = 16,
    parameter int HW       = $clog2(H_TOTAL),
    parameter int VW       = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          h_take_i,
    input  logic          v_take_i,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          frame_o
);
    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_MIDM = HW'(H_TOTAL / 2 - 1);
    localparam logic [HW-1:0] H_PRE  = HW'(H_PRESET);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_PRE  = VW'(V_PRESET);

    logic h_step;
    assign h_step = !h_take_i && ((h_o == H_LAST) || (h_o == H_MIDM));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_o     <= '0;
            v_o     <= '0;
            frame_o <= 1'b0;
        end else if (tick_i) begin
            if (h_take_i)            h_o <= H_PRE;
            else if (h_o == H_LAST)  h_o <= '0;
            else                     h_o <= h_o + 1'b1;

            if (v_take_i)            v_o <= V_PRE;
            else if (h_step)         v_o <= (v_o == V_LAST) ? '0 : v_o + 1'b1;

            if (!v_take_i && h_step && (v_o == V_LAST))
                frame_o <= ~frame_o;
        end
    end

    AST_H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(h_o) && $stable(v_o)); // R1
    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !h_take_i && h_o == H_LAST) |=> (h_o == '0)); // R2
    AST_H_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && h_take_i) |=> (h_o == H_PRE)); // R7
    AST_V_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && v_take_i) |=> (v_o == V_PRE) && $stable(frame_o)); // R8
    AST_NO_VSTEP_ON_HPRESET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && h_take_i && !v_take_i) |=> $stable(v_o)); // R10
    AST_V_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        v_o <= V_LAST); // R3
endmodule

// File: rtl/pal_video_timer.sv
module pal_video_timer #(
    parameter int TICK_DIV   = 4,
    parameter int H_TOTAL    = 214,
    parameter int V_TOTAL    = 1250,
    parameter int H_PRESET   = 6,
    parameter int V_PRESET   = 16,
    parameter int GATE_START = 5,
    parameter int GATE_END   = 112
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hsync_rst_in,
    input  logic                       vsync_rst_in,
    output logic [$clog2(H_TOTAL)-1:0] h_count,
    output logic [$clog2(V_TOTAL)-1:0] v_count,
    output logic [1:0]                 field_id,
    output logic                       line_gate
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] G_LO    = HW'(GATE_START);
    localparam logic [HW-1:0] G_HI    = HW'(GATE_END);
    localparam logic [VW-1:0] V_FIELD = VW'(V_TOTAL / 2);

    logic       tick;
    logic [1:0] pins;
    logic [1:0] take;
    logic       frame;

    assign pins = {vsync_rst_in, hsync_rst_in};

    pvt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_arm
            pvt_edge_arm u_arm (
                .clk(clk), .rst_n(rst_n), .tick_i(tick),
                .pin_i(pins[g]), .take_o(take[g])
            );
        end
    endgenerate

    pvt_line_frame_ctr #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
        .H_PRESET(H_PRESET), .V_PRESET(V_PRESET),
        .HW(HW), .VW(VW)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .h_take_i(take[0]), .v_take_i(take[1]),
        .h_o(h_count), .v_o(v_count), .frame_o(frame)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_id  <= 2'b00;
            line_gate <= 1'b0;
        end else if (tick) begin
            field_id  <= {frame, (v_count >= V_FIELD)};
            line_gate <= (h_count >= G_LO) && (h_count < G_HI);
        end
    end

    AST_DECODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(field_id) && $stable(line_gate)); // R5
    AST_GATE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && h_count == G_LO) |=> line_gate); // R6
endmodule

// File: tb/pal_video_timer_tb_top.sv
module pal_video_timer_tb_top;
    localparam int TD = 4, HT = 20, VT = 40, HP = 6, VP = 16, GS = 3, GE = 9;
    localparam int HW = $clog2(HT), VW = $clog2(VT);

    logic clk = 1'b0, rst_n = 1'b0, hin = 1'b1, vin = 1'b0;
    logic [HW-1:0] h_count;
    logic [VW-1:0] v_count;
    logic [1:0]    field_id;
    logic          line_gate;

    always #4 clk = ~clk;

    pal_video_timer #(.TICK_DIV(TD), .H_TOTAL(HT), .V_TOTAL(VT), .H_PRESET(HP),
        .V_PRESET(VP), .GATE_START(GS), .GATE_END(GE)) dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_rst_in(hin), .vsync_rst_in(vin),
        .h_count(h_count), .v_count(v_count), .field_id(field_id), .line_gate(line_gate));

    typedef struct { int h; int v; int f; int g; bit t; } snap_t;
    snap_t q[$];
    int errors = 0, checks = 0;
    int m_div, m_h, m_v, m_frame, m_f, m_g;
    bit pend_h = 0, pend_v = 0, done = 0;
    bit [3:0] seen = '0;
    event tick_ev;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, written from the requirements
    always @(posedge clk) begin
        bit t, step;
        if (!rst_n) begin
            m_div = 0; m_h = 0; m_v = 0; m_frame = 0; m_f = 0; m_g = 0;
        end else begin
            t = (m_div == TD - 1);
            if (t) begin
                m_f = m_frame * 2 + ((m_v >= VT / 2) ? 1 : 0);
                m_g = (m_h >= GS && m_h < GE) ? 1 : 0;
                step = !pend_h && (m_h == HT - 1 || m_h == HT / 2 - 1);
                if (pend_v) m_v = VP;
                else if (step) begin
                    if (m_v == VT - 1) begin m_v = 0; m_frame ^= 1; end
                    else m_v++;
                end
                if (pend_h) m_h = HP;
                else m_h = (m_h == HT - 1) ? 0 : m_h + 1;
                pend_h = 0; pend_v = 0;
                m_div = 0;
            end else m_div++;
            q.push_back('{m_h, m_v, m_f, m_g, t});
            if (t) -> tick_ev;
        end
    end

    // monitor
    always @(negedge clk) begin
        snap_t s;
        if (q.size() > 0) begin
            s = q.pop_front();
            check(h_count == s.h, s.t ? "R2 h_count" : "R1 h_count held", h_count, s.h);
            check(v_count == s.v, "R3 v_count", v_count, s.v);
            check(field_id == s.f, "R4 R5 field_id", field_id, s.f);
            check(line_gate == s.g, "R5 R6 line_gate", line_gate, s.g);
            seen[field_id] = 1'b1;
        end
    end

    task automatic wait_h(int target);
        do @(tick_ev); while (m_h != target);
    endtask

    task automatic fire(bit do_h, bit do_v);
        @(negedge clk);
        if (do_h) begin hin = 1'b1; pend_h = 1; end
        if (do_v) begin vin = 1'b1; pend_v = 1; end
        @(tick_ev);
        @(negedge clk);
    endtask

    task automatic release_pins();
        repeat (3) @(tick_ev);
        @(negedge clk);
        hin = 1'b0; vin = 1'b0;
        repeat (2) @(tick_ev);
    endtask

    initial begin
        int vb;
        repeat (3) @(negedge clk);
        check(h_count == 0 && v_count == 0, "R11 counts in reset", h_count + v_count, 0);
        check(field_id == 0 && line_gate == 0, "R11 decode in reset", field_id + line_gate, 0);
        rst_n = 1'b1;
        repeat (10) @(tick_ev);
        @(negedge clk);
        check(h_count == m_h, "R9 high through reset no preset", h_count, m_h);
        hin = 1'b0;
        repeat (2 * VT * HT / 2 + 20) @(tick_ev);
        check(seen == 4'hF, "R4 four fields seen", seen, 15);

        wait_h(12); fire(1, 0);
        check(h_count == HP, "R7 h preset", h_count, HP);
        repeat (30) @(tick_ev);
        @(negedge clk);
        check(h_count == m_h, "R9 single preset while held", h_count, m_h);
        release_pins();

        wait_h(5); fire(0, 1);
        check(v_count == VP, "R8 v preset", v_count, VP);
        release_pins();

        wait_h(HT - 1); vb = m_v; fire(1, 0);
        check(v_count == vb, "R10 h preset suppresses v step", v_count, vb);
        check(h_count == HP, "R10 h preset at wrap", h_count, HP);
        release_pins();

        wait_h(HT / 2 - 1); fire(0, 1);
        check(v_count == VP, "R10 v preset beats half step", v_count, VP);
        release_pins();

        wait_h(HT - 1); fire(1, 1);
        check(h_count == HP && v_count == VP, "R10 both presets", h_count * 100 + v_count, HP * 100 + VP);
        release_pins();

        repeat (VT * HT / 2 + 10) @(tick_ev);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule